// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Manager

This block owns every refresh operation of an asynchronous DRAM. After reset it stays quiet for a power-up pause. It then runs a short series of initialization refreshes, each with CAS going active before RAS. In normal operation it keeps a fixed-period interval timer. Each expiry makes one refresh pending. The block then asks the access sequencer for the memory with `ref_req` and starts the strobe pattern only once `ref_gnt` arrives.

On command the block moves the memory into self-refresh. It first runs one bridging CAS-before-RAS refresh, then holds both strobes active until an exit is allowed. On exit it applies the longer self-refresh precharge and runs a second bridging refresh. A row tally counts the refreshes completed since reset or since the last exit. Entry is refused until that tally covers every row. The block also guards against a RAS pulse whose width falls in the window where the part drifts between normal and self-refresh operation.

The state machine has these states:
- `ST_PAUSE`: power-up wait.
- `ST_REQ`: waiting for grant.
- `ST_CAS`, `ST_RAS`, `ST_PRE`: the three phases of a CBR cycle.
- `ST_IDLE`
- `ST_SR_CAS`: CAS lead into self-refresh.
- `ST_SR_HOLD`: RAS held.
- `ST_SR_PRE`: long precharge.

The state machine has these transitions:
- pause done: `ST_PAUSE` to `ST_REQ`.
- granted: `ST_REQ` to `ST_CAS`.
- lead done: `ST_CAS` to `ST_RAS`.
- pulse done: `ST_RAS` to `ST_PRE`.
- precharge done:
  - to `ST_REQ` (more init cycles),
  - to `ST_IDLE` (init finished, periodic, or after exit),
  - to `ST_SR_CAS` (entry bridge finished).
- refresh due or entry accepted: `ST_IDLE` to `ST_REQ`.
- strobes set: `ST_SR_CAS` to `ST_SR_HOLD`.
- exit allowed: `ST_SR_HOLD` to `ST_SR_PRE`.
- long precharge done: `ST_SR_PRE` to `ST_CAS`.

A phase register records why a CBR cycle runs: init, periodic, entry bridge or exit bridge.

Top module: `dram_refresh_mgr`

## Requirements
- R1: From reset release, `ref_req`, `ras_on` and `cas_on` stay low for exactly PAUSE_CYC clock edges, and `ref_req` first goes high after edge PAUSE_CYC. `init_done` is low throughout.
- R2: After the pause, exactly INIT_CNT CAS-before-RAS cycles run back to back. `init_done` rises after the last one.
- R3: Every refresh pulse (`ras_on`=1, active high) begins only after `cas_on` has been high alone for CAS_CYC cycles. A CBR pulse lasts RAS_CYC cycles and is followed by at least PRE_CYC cycles with both strobes low.
- R4: A refresh cycle that starts from `ST_REQ` drives no strobe until `ref_gnt` is high. `ref_req` stays high from request until the cycle completes.
- R5: After initialization, one periodic refresh becomes pending every INTERVAL_CYC cycles, so consecutive `ref_req` rises are INTERVAL_CYC cycles apart when grants come promptly.
- R6: If a second interval expires while a refresh is still pending, `overdue` goes high at that expiry. It stays high until reset, even after the refresh is served.
- R7: `full_done` is high exactly when at least ROWS CBR cycles have completed since reset or since the last self-refresh exit. It drops to 0 when RAS is released at exit.
- R8: `sr_enter_cmd` in `ST_IDLE` with `full_done`=1 causes one bridging CBR cycle, then `sr_active`=1 with CAS alone, then RAS held with CAS.
- R9: `sr_enter_cmd` in `ST_IDLE` with `full_done`=0 gives a one-cycle `sr_reject` pulse on the next cycle. No self-refresh follows.
- R10: The self-refresh RAS pulse lasts at least SR_MIN_CYC cycles. An exit command given earlier is remembered and takes effect at exactly SR_MIN_CYC.
- R11: After self-refresh, both strobes stay low for SR_PRE_CYC cycles. One bridging CBR cycle follows, so the low gap before its RAS is SR_PRE_CYC+CAS_CYC. The block then returns to `ST_IDLE`.
- R12: No RAS pulse ever has a width from FORBID_LO_CYC up to SR_MIN_CYC-1 cycles.
- R13: `sr_exit_cmd` outside self-refresh has no effect. A later self-refresh stays held until a new exit command arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Grant from the access sequencer; held while `ref_req` is high |
| sr_enter_cmd | input | 1 | One-cycle request to enter self-refresh |
| sr_exit_cmd | input | 1 | One-cycle request to leave self-refresh |
| ref_req | output | 1 | Refresh owns or wants the memory |
| ras_on | output | 1 | Request to drive RAS active (low on the pin) |
| cas_on | output | 1 | Request to drive CAS active (low on the pin) |
| init_done | output | 1 | Initialization refreshes finished |
| sr_active | output | 1 | In self-refresh, including its long precharge |
| full_done | output | 1 | Every row refreshed since reset or last exit |
| overdue | output | 1 | Sticky flag: refresh debt exceeded one interval |
| sr_reject | output | 1 | Pulse: entry refused for lack of a full refresh |

## Verification
The embedded properties check on every cycle:
- CAS leads each RAS rise.
- A granted cycle never strobes without grant.
- No RAS pulse ends inside the forbidden width window.
- The long precharge follows every self-refresh pulse.
- Entry happens only with a complete row tally.
- A reject never coincides with strobes.
- `overdue` is raised only over an existing debt.

The following can only be shown by the bench's scenarios:
- The exact pause length.
- The count of initialization cycles.
- The spacing of periodic requests.
- The row-tally threshold and its clearing at exit.
- The remembered early exit.
- The ignored idle exit.
- The stickiness of `overdue`.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [3:0] {
        ST_PAUSE,
        ST_REQ,
        ST_CAS,
        ST_RAS,
        ST_PRE,
        ST_IDLE,
        ST_SR_CAS,
        ST_SR_HOLD,
        ST_SR_PRE
    } ref_state_e;

    typedef enum logic [1:0] {
        PH_INIT,
        PH_NORM,
        PH_SR_IN,
        PH_SR_OUT
    } ref_phase_e;

    function automatic int unsigned max_of2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
    parameter int unsigned INTERVAL_CYC = 3900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    input  logic serve,
    output logic pending,
    output logic overdue
);
    localparam int unsigned TW = $clog2(INTERVAL_CYC + 1);

    logic [TW-1:0] tcnt;
    logic          tick;
    logic          debt;
    logic          late;

    assign tick = run && (tcnt == TW'(INTERVAL_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
            debt <= 1'b0;
            late <= 1'b0;
        end else if (clr) begin
            tcnt <= '0;
            debt <= 1'b0;
        end else begin
            if (run) begin
                tcnt <= tick ? '0 : tcnt + 1'b1;
            end
            if (tick) begin
                if (debt && !serve) begin
                    late <= 1'b1;
                end
                debt <= 1'b1;
            end else if (serve) begin
                debt <= 1'b0;
            end
        end
    end

    assign pending = debt;
    assign overdue = late;

    // R6
    overdue_needs_debt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overdue) |-> $past(pending));

endmodule

// File: rtl/refresh_row_tally.sv
module refresh_row_tally #(
    parameter int unsigned ROWS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic clr,
    output logic full
);
    localparam int unsigned RW = $clog2(ROWS + 1);

    logic [RW-1:0] rows_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rows_done <= '0;
        end else if (clr) begin
            rows_done <= '0;
        end else if (inc && (rows_done != RW'(ROWS))) begin
            rows_done <= rows_done + 1'b1;
        end
    end

    assign full = (rows_done == RW'(ROWS));

endmodule

// File: rtl/dram_refresh_mgr.sv
module dram_refresh_mgr
    import dram_refresh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC     = 25000,
    parameter int unsigned INIT_CNT      = 8,
    parameter int unsigned INTERVAL_CYC  = 3900,
    parameter int unsigned ROWS          = 1024,
    parameter int unsigned CAS_CYC       = 3,
    parameter int unsigned RAS_CYC       = 10,
    parameter int unsigned PRE_CYC       = 6,
    parameter int unsigned FORBID_LO_CYC = 2500,
    parameter int unsigned SR_MIN_CYC    = 25000,
    parameter int unsigned SR_PRE_CYC    = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    input  logic sr_enter_cmd,
    input  logic sr_exit_cmd,
    output logic ref_req,
    output logic ras_on,
    output logic cas_on,
    output logic init_done,
    output logic sr_active,
    output logic full_done,
    output logic overdue,
    output logic sr_reject
);
    localparam int unsigned LMAX = max_of2(max_of2(PAUSE_CYC, SR_MIN_CYC),
                                           max_of2(max_of2(CAS_CYC, RAS_CYC),
                                                   max_of2(PRE_CYC, SR_PRE_CYC)));
    localparam int unsigned CW   = $clog2(LMAX + 1);
    localparam int unsigned IW   = $clog2(INIT_CNT + 1);
    localparam int unsigned SW   = $clog2(SR_MIN_CYC + 1);
    localparam int unsigned GW   = $clog2(SR_PRE_CYC + 1);

    ref_state_e    state, state_n;
    ref_phase_e    phase, phase_n;
    logic [CW-1:0] cnt;
    logic [IW-1:0] init_left;
    logic          init_q;
    logic          exit_pend;
    logic          reject_q;
    logic          exit_seen;
    logic          exit_go;
    logic          cbr_done;
    logic          due;
    logic          timer_run;

    // ---------------- next-state logic ----------------
    assign exit_seen = exit_pend || sr_exit_cmd;

    always_comb begin
        state_n = state;
        phase_n = phase;
        unique case (state)
            ST_PAUSE: begin
                if (cnt == CW'(PAUSE_CYC - 1)) begin
                    state_n = ST_REQ;
                    phase_n = PH_INIT;
                end
            end
            ST_REQ: begin
                if (ref_gnt) state_n = ST_CAS;
            end
            ST_CAS: begin
                if (cnt == CW'(CAS_CYC - 1)) state_n = ST_RAS;
            end
            ST_RAS: begin
                if (cnt == CW'(RAS_CYC - 1)) state_n = ST_PRE;
            end
            ST_PRE: begin
                if (cnt == CW'(PRE_CYC - 1)) begin
                    unique case (phase)
                        PH_INIT:   state_n = (init_left == IW'(1)) ? ST_IDLE : ST_REQ;
                        PH_NORM:   state_n = ST_IDLE;
                        PH_SR_IN:  state_n = ST_SR_CAS;
                        PH_SR_OUT: state_n = ST_IDLE;
                    endcase
                end
            end
            ST_IDLE: begin
                if (sr_enter_cmd && full_done) begin
                    state_n = ST_REQ;
                    phase_n = PH_SR_IN;
                end else if (due) begin
                    state_n = ST_REQ;
                    phase_n = PH_NORM;
                end
            end
            ST_SR_CAS: begin
                if (cnt == CW'(CAS_CYC - 1)) state_n = ST_SR_HOLD;
            end
            ST_SR_HOLD: begin
                if (exit_seen && (cnt >= CW'(SR_MIN_CYC - 1))) state_n = ST_SR_PRE;
            end
            ST_SR_PRE: begin
                if (cnt == CW'(SR_PRE_CYC - 1)) begin
                    state_n = ST_CAS;
                    phase_n = PH_SR_OUT;
                end
            end
            default: state_n = ST_PAUSE;
        endcase
    end

    assign exit_go  = (state == ST_SR_HOLD) && (state_n == ST_SR_PRE);
    assign cbr_done = (state == ST_RAS) && (cnt == CW'(RAS_CYC - 1));

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_PAUSE;
            phase     <= PH_INIT;
            cnt       <= '0;
            init_left <= IW'(INIT_CNT);
            init_q    <= 1'b0;
            exit_pend <= 1'b0;
            reject_q  <= 1'b0;
        end else begin
            state <= state_n;
            phase <= phase_n;
            if (state_n != state) begin
                cnt <= '0;
            end else if (cnt != {CW{1'b1}}) begin
                cnt <= cnt + 1'b1;
            end
            if ((state == ST_PRE) && (phase == PH_INIT) && (state_n != ST_PRE)) begin
                init_left <= init_left - 1'b1;
                if (state_n == ST_IDLE) init_q <= 1'b1;
            end
            if (state == ST_SR_PRE) begin
                exit_pend <= 1'b0;
            end else if (sr_exit_cmd && ((state == ST_SR_CAS) || (state == ST_SR_HOLD))) begin
                exit_pend <= 1'b1;
            end
            reject_q <= (state == ST_IDLE) && sr_enter_cmd && !full_done;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        ref_req   = 1'b1;
        ras_on    = 1'b0;
        cas_on    = 1'b0;
        sr_active = 1'b0;
        unique case (state)
            ST_PAUSE, ST_IDLE: ref_req = 1'b0;
            ST_REQ, ST_PRE:    ;
            ST_CAS:            cas_on = 1'b1;
            ST_RAS: begin
                cas_on = 1'b1;
                ras_on = 1'b1;
            end
            ST_SR_CAS: begin
                cas_on    = 1'b1;
                sr_active = 1'b1;
            end
            ST_SR_HOLD: begin
                cas_on    = 1'b1;
                ras_on    = 1'b1;
                sr_active = 1'b1;
            end
            ST_SR_PRE:         sr_active = 1'b1;
            default:           ref_req = 1'b0;
        endcase
    end

    assign init_done = init_q;
    assign sr_reject = reject_q;

    assign timer_run = (state == ST_IDLE) ||
                       ((phase == PH_NORM) && (state != ST_PAUSE) && !sr_active);

    refresh_interval_timer #(
        .INTERVAL_CYC(INTERVAL_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .clr     (exit_go),
        .serve   (cbr_done),
        .pending (due),
        .overdue (overdue)
    );

    refresh_row_tally #(
        .ROWS(ROWS)
    ) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cbr_done),
        .clr   (exit_go),
        .full  (full_done)
    );

    // ---------------- checker state ----------------
    logic [SW-1:0] ras_run;
    logic [GW-1:0] gap_run;
    logic          after_sr;
    logic          ras_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_run  <= '0;
            gap_run  <= '0;
            after_sr <= 1'b0;
            ras_q    <= 1'b0;
        end else begin
            ras_q <= ras_on;
            if (!ras_on) ras_run <= '0;
            else if (ras_run != SW'(SR_MIN_CYC)) ras_run <= ras_run + 1'b1;
            if (ras_q && !ras_on && sr_active) begin
                after_sr <= 1'b1;
                gap_run  <= GW'(1);
            end else if (ras_on) begin
                after_sr <= 1'b0;
                gap_run  <= '0;
            end else if (after_sr && (gap_run != GW'(SR_PRE_CYC))) begin
                gap_run <= gap_run + 1'b1;
            end
        end
    end

    // R3
    cas_leads_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_on) |-> $past(cas_on));

    // R4
    strobe_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cas_on) && !sr_active) |-> ref_gnt);

    // R12
    ras_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_on) |-> ((ras_run < SW'(FORBID_LO_CYC)) || (ras_run >= SW'(SR_MIN_CYC))));

    // R11
    sr_long_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_on) && after_sr) |-> (gap_run >= GW'(SR_PRE_CYC)));

    // R8
    sr_entry_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_active) |-> full_done);

    // R9
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_reject |-> (!sr_active && !ras_on));

endmodule

// File: tb/dram_refresh_mgr_bench.sv
module dram_refresh_mgr_bench;

    localparam int PAUSE    = 50;
    localparam int INIT     = 4;
    localparam int INTERVAL = 60;
    localparam int ROWS     = 12;
    localparam int CASC     = 2;
    localparam int RASC     = 4;
    localparam int PREC     = 3;
    localparam int FLO      = 20;
    localparam int SRMIN    = 80;
    localparam int SRPRE    = 10;
    localparam int WDOG     = 20000;

    typedef enum int {EV_CBR, EV_SELF} ev_e;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_gnt = 1'b0;
    logic sr_enter_cmd = 1'b0;
    logic sr_exit_cmd = 1'b0;
    logic ref_req, ras_on, cas_on, init_done, sr_active, full_done, overdue, sr_reject;

    always #2 clk = ~clk;

    dram_refresh_mgr #(
        .PAUSE_CYC(PAUSE), .INIT_CNT(INIT), .INTERVAL_CYC(INTERVAL), .ROWS(ROWS),
        .CAS_CYC(CASC), .RAS_CYC(RASC), .PRE_CYC(PREC), .FORBID_LO_CYC(FLO),
        .SR_MIN_CYC(SRMIN), .SR_PRE_CYC(SRPRE)
    ) u_dram_refresh_mgr (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt),
        .sr_enter_cmd(sr_enter_cmd), .sr_exit_cmd(sr_exit_cmd),
        .ref_req(ref_req), .ras_on(ras_on), .cas_on(cas_on),
        .init_done(init_done), .sr_active(sr_active), .full_done(full_done),
        .overdue(overdue), .sr_reject(sr_reject)
    );

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  gnt_en = 1'b1;
    bit  done = 1'b0;
    ev_e exp_q[$];

    int cbr_total = 0;
    int cbr_since = 0;
    int last_self_w = 0;
    int last_self_gap = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic expect_event(input ev_e k);
        exp_q.push_back(k);
    endtask

    task automatic wait_req_rise(output int t);
        while (ref_req) @(negedge clk);
        while (!ref_req) @(negedge clk);
        t = cyc;
    endtask

    task automatic pulse_enter();
        sr_enter_cmd = 1'b1;
        @(negedge clk);
        sr_enter_cmd = 1'b0;
    endtask

    task automatic pulse_exit();
        sr_exit_cmd = 1'b1;
        @(negedge clk);
        sr_exit_cmd = 1'b0;
    endtask

    task automatic wait_idle();
        while (ref_req) @(negedge clk);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // sequencer model: grant follows request half a cycle later
    initial begin
        forever begin
            @(negedge clk);
            ref_gnt = gnt_en && ref_req && rst_n;
        end
    end

    // monitor: decodes strobe pulses and pops the scoreboard
    initial begin
        bit  pr_ras = 1'b0;
        bit  after_self = 1'b0;
        bit  seen_fall = 1'b0;
        int  ras_hi = 0;
        int  gap_lo = 0;
        int  cas_lead = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            if (ras_on && !pr_ras) begin
                check(cas_lead == CASC, "R3 cas lead", cas_lead, CASC);
                if (after_self) begin
                    last_self_gap = gap_lo;
                    check(gap_lo >= SRPRE, "R11 long precharge", gap_lo, SRPRE);
                end else if (seen_fall) begin
                    check(gap_lo >= PREC, "R3 precharge", gap_lo, PREC);
                end
                ras_hi = 0;
            end
            if (!ras_on && pr_ras) begin
                ev_e k;
                k = (ras_hi >= SRMIN) ? EV_SELF : EV_CBR;
                check((ras_hi < FLO) || (ras_hi >= SRMIN), "R12 ras width window", ras_hi, FLO);
                if (k == EV_CBR) begin
                    check(ras_hi == RASC, "R3 cbr width", ras_hi, RASC);
                    cbr_total++;
                    cbr_since++;
                    check(full_done == (cbr_since >= ROWS), "R7 full flag", full_done, cbr_since >= ROWS);
                    after_self = 1'b0;
                end else begin
                    last_self_w = ras_hi;
                    check(ras_hi >= SRMIN, "R10 self width", ras_hi, SRMIN);
                    cbr_since = 0;
                    check(full_done == 1'b0, "R7 cleared at exit", full_done, 0);
                    after_self = 1'b1;
                end
                if (exp_q.size() > 0) begin
                    ev_e e;
                    e = exp_q.pop_front();
                    check(e == k, "R2/R8/R11 event order", k, e);
                end else begin
                    check(k == EV_CBR, "R13 unexpected self-refresh", k, EV_CBR);
                end
                seen_fall = 1'b1;
                gap_lo = 0;
            end
            if (ras_on) ras_hi++;
            else gap_lo++;
            if (cas_on && !ras_on) cas_lead++;
            else if (!cas_on) cas_lead = 0;
            pr_ras = ras_on;
        end
    end

    // watchdog
    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        int t1;
        int t2;
        repeat (3) @(negedge clk);
        check(!ref_req && !ras_on && !cas_on, "R1 reset strobes", {ref_req, ras_on, cas_on}, 0);
        check(!init_done && !sr_active && !overdue, "R1 reset flags", {init_done, sr_active, overdue}, 0);
        for (int i = 0; i < INIT; i++) expect_event(EV_CBR);
        rst_n = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            if (!ref_req) check(!ras_on && !cas_on && !init_done, "R1 quiet pause", ras_on, 0);
        end while (!ref_req);
        check(k == PAUSE, "R1 pause length", k, PAUSE);

        while (!init_done) @(negedge clk);
        check(exp_q.size() == 0, "R2 init events done", exp_q.size(), 0);
        check(cbr_total == INIT, "R2 init count", cbr_total, INIT);

        wait_req_rise(t1);
        wait_req_rise(t2);
        check((t2 - t1) == INTERVAL, "R5 interval", t2 - t1, INTERVAL);

        // R13: exit while idle is ignored
        wait_idle();
        pulse_exit();
        repeat (4) @(negedge clk);
        check(!sr_active, "R13 idle exit", sr_active, 0);

        // R9: entry without full refresh
        wait_idle();
        check(!full_done, "R9 precondition", full_done, 0);
        pulse_enter();
        check(sr_reject, "R9 reject pulse", sr_reject, 1);
        @(negedge clk);
        check(!sr_reject && !sr_active, "R9 no entry", {sr_reject, sr_active}, 0);

        // first self-refresh, held long
        while (!full_done) @(negedge clk);
        wait_idle();
        expect_event(EV_CBR);
        expect_event(EV_SELF);
        expect_event(EV_CBR);
        pulse_enter();
        while (!sr_active) @(negedge clk);
        check(exp_q.size() == 2, "R8 bridge before entry", exp_q.size(), 2);
        check(cas_on && !ras_on, "R8 cas first", {cas_on, ras_on}, 2);
        repeat (SRMIN + 30) @(negedge clk);
        check(sr_active && ras_on, "R13 held without new exit", {sr_active, ras_on}, 3);
        pulse_exit();
        while (sr_active) @(negedge clk);
        check(!full_done, "R7 cleared after exit", full_done, 0);
        while (exp_q.size() != 0) @(negedge clk);
        check(last_self_gap == SRPRE + CASC, "R11 gap before bridge", last_self_gap, SRPRE + CASC);
        wait_idle();
        check(!ref_req && !sr_active, "R11 back to idle", {ref_req, sr_active}, 0);

        wait_idle();
        pulse_enter();
        check(sr_reject, "R9 reject after exit", sr_reject, 1);

        // second self-refresh, early exit
        while (!full_done) @(negedge clk);
        wait_idle();
        expect_event(EV_CBR);
        expect_event(EV_SELF);
        expect_event(EV_CBR);
        pulse_enter();
        while (!sr_active) @(negedge clk);
        repeat (10) @(negedge clk);
        pulse_exit();
        while (exp_q.size() != 0) @(negedge clk);
        check(last_self_w == SRMIN, "R10 early exit held to minimum", last_self_w, SRMIN);

        // R6 overdue with grant withheld
        wait_idle();
        check(!overdue, "R6 clean before", overdue, 0);
        gnt_en = 1'b0;
        wait_req_rise(t1);
        repeat (INTERVAL - 3) @(negedge clk);
        check(!overdue, "R6 one interval debt allowed", overdue, 0);
        check(!cas_on && !ras_on, "R4 no strobe without grant", {cas_on, ras_on}, 0);
        repeat (4) @(negedge clk);
        check(overdue, "R6 overdue raised", overdue, 1);
        gnt_en = 1'b1;
        wait_idle();
        repeat (2) @(negedge clk);
        check(overdue, "R6 overdue sticky", overdue, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule